// File: doc/BRIEF.md
# Dual-Reference Clock Switching Controller

This block decides which of two timing references, a primary and a secondary, a digital PLL should follow. It also decides when the PLL has to coast on stored values (holdover) and when it has lost lock. It does not measure references. Two validity flags come from frequency-checking logic outside the block. A small configuration register, written through a one-cycle strobe, holds a 2-bit failure-policy field and a preferred-reference bit.

There are three policies. In the automatic policy the controller follows the preferred reference and reverts to it when it recovers. When the tracked reference fails, the PLL coasts in holdover for at least `HOLD_CYCLES` clocks before the controller moves it to the other reference. In the two pinned policies the controller follows one reference only, never coasts, and flags lock loss while that reference is bad. A 3-bit state code and two registered validity bits are provided for status readback.

Top module: `refsw_ctrl`

## Requirements
- R1: The policy field `cfg_mode` decodes as 2'b01 = pinned primary, 2'b10 = pinned secondary, and 2'b00 or 2'b11 = automatic. The field and `cfg_pref_sec` (1 = secondary preferred) are stored on a clock edge where `cfg_wr` is 1.
- R2: While `rst` is high, and in the first cycle after it falls, `state_code` is 0 and `sel_sec`, `holdover`, `lock_lost`, `prim_ok_stat` and `sec_ok_stat` are 0. Reset selects the automatic policy with the primary preferred.
- R3: In the automatic policy, state 0 moves on the next edge to tracking the preferred reference: code 1 for primary, code 3 for secondary.
- R4: In the automatic policy, if the tracked reference is invalid at an edge, the next state is its holdover state: code 2 from primary, code 4 from secondary. `holdover` is then 1 and `sel_sec` does not change.
- R5: A holdover state is left for the other reference only after at least `HOLD_CYCLES` cycles in holdover, and only when that reference is valid. If the reference that was being tracked is valid again, the controller returns to it on the next edge.
- R6: In the automatic policy, when the non-preferred reference is being tracked and the preferred one is valid, the controller moves to the preferred reference on the next edge.
- R7: A write that changes only `cfg_pref_sec` does not restart the state machine. Making the current backup the preferred reference therefore stops any revert.
- R8: In the automatic policy, with both references invalid, the controller stays in its holdover state with `holdover` = 1.
- R9: In pinned-primary policy, the state is code 1 when `prim_ok` was 1 at the edge and code 5 otherwise. `sel_sec` and `holdover` stay 0, `lock_lost` is 1 only in code 5, and `cfg_pref_sec` has no effect.
- R10: Pinned-secondary policy mirrors R9: code 3 or code 5, decided by `sec_ok`, with `sel_sec` = 1 and `holdover` = 0.
- R11: State codes are 0 init, 1 track primary, 2 holdover from primary, 3 track secondary, 4 holdover from secondary, 5 pinned unlocked. `prim_ok_stat` and `sec_ok_stat` equal the validity inputs one cycle earlier.
- R12: A write that changes the decoded policy takes effect on that edge. The machine restarts as if from state 0 under the new policy and the written preference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Failure-policy field to write |
| cfg_pref_sec | input | 1 | Preferred reference to write (1 = secondary) |
| prim_ok | input | 1 | Primary reference valid |
| sec_ok | input | 1 | Secondary reference valid |
| sel_sec | output | 1 | Reference the PLL follows (1 = secondary) |
| holdover | output | 1 | PLL must coast on stored values |
| lock_lost | output | 1 | Pinned reference has failed |
| state_code | output | 3 | Current state number |
| prim_ok_stat | output | 1 | Registered primary validity |
| sec_ok_stat | output | 1 | Registered secondary validity |

## Verification
Every policy value and preference is combined with every ordered pair of validity patterns, and the second pattern is held for one to five cycles. With a dwell of three, this separates a switch that comes too early from one that waits. It also separates a recovery from a failover, and a revert from a sticky backup. Directed sequences walk a failover, a revert, a preference change that blocks the revert, both references lost, and pinned-policy loss and recovery. Policy writes issued mid-run check that a restart happens exactly when the decoded policy changes and not when only the preference does.

// File: rtl/refsw_pkg.sv
package refsw_pkg;
   localparam int MODE_W  = 2;
   localparam int STATE_W = 3;

   typedef enum logic [STATE_W-1:0] {
      ST_INIT  = 3'd0,
      ST_TRK_P = 3'd1,
      ST_HLD_P = 3'd2,
      ST_TRK_S = 3'd3,
      ST_HLD_S = 3'd4,
      ST_LOST  = 3'd5
   } sw_state_e;

   typedef enum logic [1:0] {
      POL_AUTO  = 2'd0,
      POL_FRC_P = 2'd1,
      POL_FRC_S = 2'd2
   } policy_e;

   typedef struct packed {
      policy_e pol;
      logic    pref_sec;
   } sw_cfg_t;

   function automatic policy_e decode_mode(input logic [MODE_W-1:0] f);
      case (f)
         2'b01:   return POL_FRC_P;
         2'b10:   return POL_FRC_S;
         default: return POL_AUTO;
      endcase
   endfunction

   function automatic logic is_hold(input sw_state_e s);
      return (s == ST_HLD_P) || (s == ST_HLD_S);
   endfunction
endpackage

// File: rtl/refsw_cfg.sv
module refsw_cfg
   import refsw_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              wr,
   input  logic [MODE_W-1:0] mode_in,
   input  logic              pref_in,
   output sw_cfg_t           cur_cfg,
   output sw_cfg_t           eff_cfg,
   output logic              restart
);
   sw_cfg_t cfg_q;
   policy_e new_pol;

   assign new_pol = decode_mode(mode_in);
   assign restart = wr && (new_pol != cfg_q.pol);

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_q.pol      <= POL_AUTO;
         cfg_q.pref_sec <= 1'b0;
      end else if (wr) begin
         cfg_q.pol      <= new_pol;
         cfg_q.pref_sec <= pref_in;
      end
   end

   always_comb begin
      eff_cfg = cfg_q;
      if (restart) begin
         eff_cfg.pol      = new_pol;
         eff_cfg.pref_sec = pref_in;
      end
   end

   assign cur_cfg = cfg_q;
endmodule

// File: rtl/refsw_dwell.sv
module refsw_dwell #(
   parameter int HOLD_CYCLES = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic in_hold,
   output logic done
);
   localparam int             CNT_W = $clog2(HOLD_CYCLES + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || !in_hold) cnt_q <= '0;
      else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
   end

   assign done = (cnt_q == LAST);
endmodule

// File: rtl/refsw_fsm.sv
module refsw_fsm
   import refsw_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      restart,
   input  sw_cfg_t   eff_cfg,
   input  logic      prim_ok,
   input  logic      sec_ok,
   input  logic      dwell_done,
   output sw_state_e state_q
);
   sw_state_e base, nxt, entry;

   assign base  = restart ? ST_INIT : state_q;
   assign entry = eff_cfg.pref_sec ? ST_TRK_S : ST_TRK_P;

   always_comb begin
      nxt = base;
      case (eff_cfg.pol)
         POL_FRC_P: nxt = prim_ok ? ST_TRK_P : ST_LOST;
         POL_FRC_S: nxt = sec_ok  ? ST_TRK_S : ST_LOST;
         default: begin
            case (base)
               ST_TRK_P: begin
                  if (!prim_ok)                       nxt = ST_HLD_P;
                  else if (eff_cfg.pref_sec && sec_ok) nxt = ST_TRK_S;
               end
               ST_HLD_P: begin
                  if (prim_ok)                        nxt = ST_TRK_P;
                  else if (dwell_done && sec_ok)       nxt = ST_TRK_S;
               end
               ST_TRK_S: begin
                  if (!sec_ok)                        nxt = ST_HLD_S;
                  else if (!eff_cfg.pref_sec && prim_ok) nxt = ST_TRK_P;
               end
               ST_HLD_S: begin
                  if (sec_ok)                         nxt = ST_TRK_S;
                  else if (dwell_done && prim_ok)      nxt = ST_TRK_P;
               end
               default: nxt = entry;
            endcase
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_INIT;
      else     state_q <= nxt;
   end
endmodule

// File: rtl/refsw_ctrl.sv
module refsw_ctrl
   import refsw_pkg::*;
#(
   parameter int HOLD_CYCLES = 16,
   parameter bit STATUS_FLOP = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               cfg_wr,
   input  logic [MODE_W-1:0]  cfg_mode,
   input  logic               cfg_pref_sec,
   input  logic               prim_ok,
   input  logic               sec_ok,
   output logic               sel_sec,
   output logic               holdover,
   output logic               lock_lost,
   output logic [STATE_W-1:0] state_code,
   output logic               prim_ok_stat,
   output logic               sec_ok_stat
);
   initial begin
      if (HOLD_CYCLES < 1) $fatal(1, "HOLD_CYCLES must be at least 1");
   end

   sw_cfg_t   cur_cfg, eff_cfg;
   logic      restart, dwell_done;
   sw_state_e state_q;

   refsw_cfg u_cfg (
      .clk(clk), .rst(rst), .wr(cfg_wr), .mode_in(cfg_mode),
      .pref_in(cfg_pref_sec), .cur_cfg(cur_cfg), .eff_cfg(eff_cfg),
      .restart(restart)
   );

   refsw_dwell #(.HOLD_CYCLES(HOLD_CYCLES)) u_dwell (
      .clk(clk), .rst(rst), .in_hold(is_hold(state_q)), .done(dwell_done)
   );

   refsw_fsm u_fsm (
      .clk(clk), .rst(rst), .restart(restart), .eff_cfg(eff_cfg),
      .prim_ok(prim_ok), .sec_ok(sec_ok), .dwell_done(dwell_done),
      .state_q(state_q)
   );

   assign sel_sec    = (state_q == ST_TRK_S) || (state_q == ST_HLD_S) ||
                       ((state_q == ST_LOST) && (cur_cfg.pol == POL_FRC_S));
   assign holdover   = is_hold(state_q);
   assign lock_lost  = (state_q == ST_LOST);
   assign state_code = state_q;

   generate
      if (STATUS_FLOP) begin : g_stat_flop
         always_ff @(posedge clk) begin
            if (rst) begin
               prim_ok_stat <= 1'b0;
               sec_ok_stat  <= 1'b0;
            end else begin
               prim_ok_stat <= prim_ok;
               sec_ok_stat  <= sec_ok;
            end
         end
      end else begin : g_stat_wire
         assign prim_ok_stat = prim_ok;
         assign sec_ok_stat  = sec_ok;
      end
   endgenerate
endmodule

// File: rtl/refsw_ctrl_chk.sv
module refsw_ctrl_chk
   import refsw_pkg::*;
#(
   parameter int HOLD_CYCLES = 16,
   parameter bit STATUS_FLOP = 1'b1
) (
   input logic         clk,
   input logic         rst,
   input logic         cfg_wr,
   input logic [1:0]   cfg_mode,
   input logic         cfg_pref_sec,
   input logic         prim_ok,
   input logic         sec_ok,
   input logic         sel_sec,
   input logic         holdover,
   input logic         lock_lost,
   input logic [2:0]   state_code,
   input logic         prim_ok_stat,
   input logic         sec_ok_stat
);
   localparam int AGE_W = $clog2(HOLD_CYCLES + 2);

   policy_e          pol_sh, eff_pol;
   logic             pref_sh, restart_c;
   logic [AGE_W-1:0] age_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pol_sh  <= POL_AUTO;
         pref_sh <= 1'b0;
         age_q   <= '0;
      end else begin
         if (cfg_wr) begin
            pol_sh  <= decode_mode(cfg_mode);
            pref_sh <= cfg_pref_sec;
         end
         if (!holdover) age_q <= '0;
         else if (32'(age_q) < HOLD_CYCLES) age_q <= age_q + 1'b1;
      end
   end

   assign eff_pol   = cfg_wr ? decode_mode(cfg_mode) : pol_sh;
   assign restart_c = cfg_wr && (decode_mode(cfg_mode) != pol_sh);

   assert_init_R2: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (state_code == 3'd0 && !holdover && !lock_lost));

   assert_enter_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (!cfg_wr && pol_sh == POL_AUTO && state_code == 3'd1 && !prim_ok)
      |=> (state_code == 3'd2 && holdover && !sel_sec));

   assert_dwell_p_R5: assert property (@(posedge clk) disable iff (rst)
      (!restart_c && state_code == 3'd2 && 32'(age_q) + 1 < HOLD_CYCLES)
      |=> (state_code != 3'd3));

   assert_dwell_s_R5: assert property (@(posedge clk) disable iff (rst)
      (!restart_c && state_code == 3'd4 && 32'(age_q) + 1 < HOLD_CYCLES)
      |=> (state_code != 3'd1));

   assert_revert_R6: assert property (@(posedge clk) disable iff (rst)
      (!cfg_wr && pol_sh == POL_AUTO && !pref_sh && state_code == 3'd3 &&
       prim_ok && sec_ok) |=> (state_code == 3'd1));

   assert_both_bad_R8: assert property (@(posedge clk) disable iff (rst)
      (!restart_c && pol_sh == POL_AUTO && holdover && !prim_ok && !sec_ok)
      |=> (holdover && state_code == $past(state_code)));

   assert_pin_p_R9: assert property (@(posedge clk) disable iff (rst)
      (eff_pol == POL_FRC_P) |=> (!holdover && !sel_sec));

   assert_lost_R9: assert property (@(posedge clk) disable iff (rst)
      (eff_pol == POL_FRC_P && !prim_ok) |=> (lock_lost && state_code == 3'd5));

   assert_pin_s_R10: assert property (@(posedge clk) disable iff (rst)
      (eff_pol == POL_FRC_S) |=> (!holdover && sel_sec));

   generate
      if (STATUS_FLOP) begin : g_stat_chk
         assert_status_R11: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (prim_ok_stat == $past(prim_ok) && sec_ok_stat == $past(sec_ok)));
      end
   endgenerate
endmodule

bind refsw_ctrl refsw_ctrl_chk #(.HOLD_CYCLES(HOLD_CYCLES), .STATUS_FLOP(STATUS_FLOP)) u_chk (
   .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
   .cfg_pref_sec(cfg_pref_sec), .prim_ok(prim_ok), .sec_ok(sec_ok),
   .sel_sec(sel_sec), .holdover(holdover), .lock_lost(lock_lost),
   .state_code(state_code), .prim_ok_stat(prim_ok_stat), .sec_ok_stat(sec_ok_stat)
);

// File: tb/refsw_ctrl_test.sv
module refsw_ctrl_test;
   localparam int CLK_P = 10;
   localparam int HC    = 3;

   logic clk = 1'b0, rst = 1'b1, cfg_wr = 1'b0, cfg_pref_sec = 1'b0;
   logic [1:0] cfg_mode = 2'b00;
   logic prim_ok = 1'b0, sec_ok = 1'b0;
   logic sel_sec, holdover, lock_lost, prim_ok_stat, sec_ok_stat;
   logic [2:0] state_code;

   int checks = 0, errors = 0;
   int m_state, m_age, m_pol, m_pref, m_pst, m_sst;

   refsw_ctrl #(.HOLD_CYCLES(HC)) uut (
      .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
      .cfg_pref_sec(cfg_pref_sec), .prim_ok(prim_ok), .sec_ok(sec_ok),
      .sel_sec(sel_sec), .holdover(holdover), .lock_lost(lock_lost),
      .state_code(state_code), .prim_ok_stat(prim_ok_stat), .sec_ok_stat(sec_ok_stat)
   );

   always #(CLK_P/2) clk = ~clk;

   function automatic int dec(input int f);
      return (f == 1) ? 1 : (f == 2) ? 2 : 0;
   endfunction

   task automatic compare(input string tag);
      logic [7:0] got, exp;
      logic esel;
      esel = (m_state == 3) || (m_state == 4) || (m_state == 5 && m_pol == 2);
      exp = {3'(m_state), esel, (m_state == 2 || m_state == 4), (m_state == 5),
             1'(m_pst), 1'(m_sst)};
      got = {state_code, sel_sec, holdover, lock_lost, prim_ok_stat, sec_ok_stat};
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s t=%0t got %b exp %b (state,sel,hold,lost,pst,sst)", tag, $time, got, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1; cfg_wr = 1'b0; prim_ok = 1'b0; sec_ok = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst = 1'b0;
      m_state = 0; m_age = 0; m_pol = 0; m_pref = 0; m_pst = 0; m_sst = 0;
      compare("R2");
   endtask

   // one clock: drive inputs, advance the model from the requirements, check
   task automatic step(input int p, input int s, input int wr, input int cm,
                       input int cp, input string tag);
      int cpol, pol, pf, st, ns;
      bit restart;
      prim_ok = 1'(p); sec_ok = 1'(s); cfg_wr = 1'(wr);
      cfg_mode = 2'(cm); cfg_pref_sec = 1'(cp);
      cpol = dec(cm);
      restart = (wr != 0) && (cpol != m_pol);
      pol = restart ? cpol : m_pol;
      pf  = restart ? cp : m_pref;
      st  = restart ? 0 : m_state;
      if (pol == 1)      ns = p ? 1 : 5;
      else if (pol == 2) ns = s ? 3 : 5;
      else begin
         ns = st;
         case (st)
            1: ns = !p ? 2 : (pf && s) ? 3 : 1;
            2: ns = p ? 1 : (m_age >= HC && s) ? 3 : 2;
            3: ns = !s ? 4 : (!pf && p) ? 1 : 3;
            4: ns = s ? 3 : (m_age >= HC && p) ? 1 : 4;
            default: ns = pf ? 3 : 1;
         endcase
      end
      if (ns == 2 || ns == 4) m_age = (ns == st) ? m_age + 1 : 1;
      else m_age = 0;
      m_state = ns;
      if (wr != 0) begin m_pol = cpol; m_pref = cp; end
      m_pst = p; m_sst = s;
      @(posedge clk);
      #1;
      compare(tag);
   endtask

   initial begin
      #(CLK_P * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      do_reset();
      // directed: automatic policy, primary preferred
      step(1, 1, 0, 0, 0, "R3");
      step(0, 1, 0, 0, 0, "R4");
      for (int i = 0; i < HC; i++) step(0, 1, 0, 0, 0, "R5");
      step(1, 1, 0, 0, 0, "R6");
      step(0, 1, 0, 0, 0, "R4");
      for (int i = 0; i < HC; i++) step(0, 1, 0, 0, 0, "R5");
      step(0, 1, 1, 0, 1, "R7");
      step(1, 1, 0, 0, 0, "R7");
      step(1, 1, 0, 0, 0, "R7");
      for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, "R8");
      step(1, 0, 0, 0, 0, "R8");
      step(1, 1, 0, 0, 0, "R6");
      step(1, 0, 0, 0, 0, "R11");
      step(0, 1, 0, 0, 0, "R11");
      step(1, 1, 1, 1, 0, "R12");
      step(0, 1, 0, 0, 0, "R9");
      step(1, 1, 0, 0, 0, "R9");
      step(1, 1, 1, 1, 1, "R9");
      step(1, 1, 1, 2, 0, "R12");
      step(1, 0, 0, 0, 0, "R10");
      step(1, 1, 0, 0, 0, "R10");
      step(1, 1, 1, 3, 0, "R1");
      step(1, 1, 1, 0, 1, "R7");

      // sweep: every policy value x preference x ordered validity pair x dwell
      for (int m = 0; m < 4; m++) begin
         for (int pf = 0; pf < 2; pf++) begin
            string tg;
            tg = (m == 1) ? "R9" : (m == 2) ? "R10" : "R5";
            do_reset();
            step(1, 1, 1, m, pf, "R1");
            for (int a = 0; a < 4; a++)
               for (int b = 0; b < 4; b++)
                  for (int len = 1; len <= 5; len++) begin
                     step(a & 1, a >> 1, 0, 0, 0, tg);
                     step(a & 1, a >> 1, 0, 0, 0, tg);
                     for (int k = 0; k < len; k++) step(b & 1, b >> 1, 0, 0, 0, tg);
                     if (len == 5) begin
                        step(b & 1, b >> 1, 1, m, 1 - pf, "R7");
                        step(b & 1, b >> 1, 1, m, pf, "R7");
                     end
                  end
         end
      end

      // sweep: policy rewrites mid-run under each validity pattern
      for (int m1 = 0; m1 < 4; m1++)
         for (int m2 = 0; m2 < 4; m2++)
            for (int v = 0; v < 4; v++) begin
               do_reset();
               step(1, 1, 1, m1, 1, "R12");
               step(0, 1, 0, 0, 0, "R12");
               step(v & 1, v >> 1, 1, m2, 0, "R12");
               for (int k = 0; k < HC + 2; k++) step(v & 1, v >> 1, 0, 0, 0, "R12");
            end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule